// File: doc/BRIEF.md
# Double-Buffered Frequency Word Register Bank

This block holds the tuning words of a numerically controlled oscillator. A host loads them one byte at a time through a narrow write-only port with its own write strobe clock, an active-low write enable, a 4-bit byte address and an 8-bit data bus. Each byte lands in a shadow (master) set clocked by the strobe. The oscillator never reads the shadow set. It reads a live (slave) set in the core clock domain, so a 48-bit word can be replaced at a single core clock edge.

Copying from shadow to live is driven by an asynchronous active-low update input. The input first passes through a synchronizer. While update is held low the live set tracks the shadow set on every core cycle, and the output shows each byte as it arrives. If the host keeps update high until every byte is written and then pulses it, the whole word changes together. The block also carries a center-term enable and an accumulator feedback enable. The reset input only takes effect when update is also low.

Top module: `freq_word_bank`

## Requirements
- R1: A byte is stored on the rising edge of `wr_clk` only when `wr_en_n` is 0. A strobe with `wr_en_n` at 1 changes nothing.
- R2: Byte addresses 0..5 form the 48-bit center word and 6..11 form the 48-bit offset word. In each word the least significant byte sits at the lowest address.
- R3: After reset the center word is 48'h4000_0000_0000 and the offset word is 0. The center enable and the feedback enable are both 1.
- R4: Address 12 bit 0 is the center enable. When it is 0, `center_term` is zero and the stored center bytes are kept. Setting it back to 1 restores them.
- R5: Address 13 bit 5 drives `accum_fb_en`.
- R6: The other bits of addresses 12 and 13 are ignored, and so are writes to addresses 14 and 15.
- R7: While `upd_n` is held low, the live set copies the shadow set on every core edge. A single new byte therefore appears on its own.
- R8: While the synchronized update is inactive, the outputs hold. A pulse given after all writes changes every byte at one edge, with no mix of old and new bytes.
- R9: `upd_n` passes through a 2-stage synchronizer. After it falls, the first copy happens on the third core edge.
- R10: Reset acts on a core edge where `rst_n` and `upd_n` are both 0. Driving `rst_n` low while `upd_n` is high has no effect.
- R11: The shadow set ignores writes until the first core edge after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core (oscillator) clock |
| rst_n | input | 1 | Active-low reset, qualified by `upd_n` low |
| upd_n | input | 1 | Active-low asynchronous shadow-to-live transfer |
| wr_clk | input | 1 | Write strobe; data captured on its rising edge |
| wr_en_n | input | 1 | Active-low write enable |
| wr_addr | input | 4 | Byte register address |
| wr_data | input | 8 | Byte to store |
| center_term | output | 48 | Live center word, or zero when disabled |
| offset_word | output | 48 | Live offset word |
| accum_fb_en | output | 1 | Live accumulator feedback enable |

## Verification
A wrong shadow byte stays out of sight until a transfer. It then shows up on `center_term` or `offset_word` at the third core edge after `upd_n` falls. A live set that copies when it should not shows at the edge after the stray copy, because an output changes while update is inactive. A synchronizer with the wrong depth moves the first changed cycle by one or more edges, and a reset that ignores its qualification leaves the default words showing where the written ones belong. The bench models both domains in behaviour and compares all outputs every core cycle, so each of these faults is caught within a cycle of the edge where it first shows.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int BYTE_W     = 8;
  localparam int FREQ_BYTES = 6;
  localparam int FREQ_W     = FREQ_BYTES * BYTE_W;
  localparam int NREG       = 2 * FREQ_BYTES;
  localparam int BANK_W     = NREG * BYTE_W;
  localparam int ADDR_W     = 4;
  localparam int CE_ADDR    = NREG;
  localparam int CE_BIT     = 0;
  localparam int FB_ADDR    = NREG + 1;
  localparam int FB_BIT     = 5;
  localparam logic [BYTE_W-1:0] TOP_CENTER_DEFAULT = 8'h40;

  // Reset value of one frequency byte: only the top center byte is non-zero.
  function automatic logic [BYTE_W-1:0] byte_default(input int idx);
    return (idx == FREQ_BYTES - 1) ? TOP_CENTER_DEFAULT : '0;
  endfunction

  function automatic logic [BANK_W-1:0] bank_default();
    logic [BANK_W-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*BYTE_W +: BYTE_W] = byte_default(i);
    return v;
  endfunction

  // Center term seen by the accumulator.
  function automatic logic [FREQ_W-1:0] center_gate(input logic [FREQ_W-1:0] cf,
                                                    input logic en);
    return en ? cf : '0;
  endfunction
endpackage

// File: rtl/fwb_sync.sv
module fwb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic set,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (set) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fwb_master.sv
module fwb_master
  import fwb_pkg::*;
(
  input  logic              wr_clk,
  input  logic              clr,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BANK_W-1:0] mst_bytes,
  output logic              mst_ce,
  output logic              mst_fb
);
  for (genvar g = 0; g < NREG; g++) begin : g_byte
    always_ff @(posedge wr_clk or posedge clr) begin
      if (clr)
        mst_bytes[g*BYTE_W +: BYTE_W] <= byte_default(g);
      else if (!wr_en_n && wr_addr == ADDR_W'(g))
        mst_bytes[g*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_ff @(posedge wr_clk or posedge clr) begin
    if (clr) begin
      mst_ce <= 1'b1;
      mst_fb <= 1'b1;
    end else if (!wr_en_n) begin
      if (wr_addr == ADDR_W'(CE_ADDR)) mst_ce <= wr_data[CE_BIT];
      if (wr_addr == ADDR_W'(FB_ADDR)) mst_fb <= wr_data[FB_BIT];
    end
  end
endmodule

// File: rtl/fwb_core.sv
module fwb_core
  import fwb_pkg::*;
(
  input  logic              core_clk,
  input  logic              rst_act,
  input  logic              upd_live,
  input  logic [BANK_W-1:0] mst_bytes,
  input  logic              mst_ce,
  input  logic              mst_fb,
  output logic [BANK_W-1:0] slv_bytes,
  output logic              slv_ce,
  output logic              slv_fb
);
  always_ff @(posedge core_clk) begin
    if (rst_act) begin
      slv_bytes <= bank_default();
      slv_ce    <= 1'b1;
      slv_fb    <= 1'b1;
    end else if (upd_live) begin
      slv_bytes <= mst_bytes;
      slv_ce    <= mst_ce;
      slv_fb    <= mst_fb;
    end
  end
endmodule

// File: rtl/freq_word_bank.sv
module freq_word_bank
  import fwb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              core_clk,
  input  logic              rst_n,
  input  logic              upd_n,
  input  logic              wr_clk,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [FREQ_W-1:0] center_term,
  output logic [FREQ_W-1:0] offset_word,
  output logic              accum_fb_en
);
  // Named internal events, also used by the bound checker.
  logic              rst_act;
  logic              rst_q;
  logic              upd_live;
  logic [BANK_W-1:0] mst_bytes;
  logic              mst_ce, mst_fb;
  logic [FREQ_W-1:0] mst_of;
  logic [BANK_W-1:0] slv_bytes;
  logic              slv_ce, slv_fb;

  assign rst_act = !rst_n && !upd_n;

  // Registered reset: clears the write domain asynchronously and holds it
  // until the first core edge after release.
  always_ff @(posedge core_clk) rst_q <= rst_act;

  fwb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (core_clk),
    .set (rst_act),
    .d   (!upd_n),
    .q   (upd_live)
  );

  fwb_master u_master (
    .wr_clk    (wr_clk),
    .clr       (rst_q),
    .wr_en_n   (wr_en_n),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mst_bytes (mst_bytes),
    .mst_ce    (mst_ce),
    .mst_fb    (mst_fb)
  );

  fwb_core u_core (
    .core_clk  (core_clk),
    .rst_act   (rst_act),
    .upd_live  (upd_live),
    .mst_bytes (mst_bytes),
    .mst_ce    (mst_ce),
    .mst_fb    (mst_fb),
    .slv_bytes (slv_bytes),
    .slv_ce    (slv_ce),
    .slv_fb    (slv_fb)
  );

  assign mst_of      = mst_bytes[2*FREQ_W-1:FREQ_W];
  assign center_term = center_gate(slv_bytes[FREQ_W-1:0], slv_ce);
  assign offset_word = slv_bytes[2*FREQ_W-1:FREQ_W];
  assign accum_fb_en = slv_fb;
endmodule

// File: rtl/fwb_check.sv
module fwb_check
  import fwb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic              core_clk,
  input logic              rst_act,
  input logic              rst_q,
  input logic              upd_n,
  input logic              upd_live,
  input logic              mst_fb,
  input logic [FREQ_W-1:0] mst_of,
  input logic [FREQ_W-1:0] center_term,
  input logic [FREQ_W-1:0] offset_word,
  input logic              accum_fb_en
);
  logic rst_any;
  assign rst_any = rst_q || rst_act;

  // R8: no synchronized update means every output holds
  a_r8_hold_when_idle: assert property (@(posedge core_clk) disable iff (rst_any)
    !upd_live |=> ($stable(center_term) && $stable(offset_word) && $stable(accum_fb_en)));

  // R7: an active synchronized update copies the shadow set
  a_r7_copy_live: assert property (@(posedge core_clk) disable iff (rst_any)
    upd_live |=> (offset_word == $past(mst_of) && accum_fb_en == $past(mst_fb)));

  // R3: the edge after a reset edge shows the default words
  a_r3_reset_values: assert property (@(posedge core_clk) disable iff (rst_act)
    rst_q |-> (center_term == {TOP_CENTER_DEFAULT, {(FREQ_W-BYTE_W){1'b0}}}
               && offset_word == '0 && accum_fb_en));

  // R9: the synchronized update rises only after update was low SYNC_STAGES edges earlier
  a_r9_sync_latency: assert property (@(posedge core_clk) disable iff (rst_any)
    $rose(upd_live) |-> !$past(upd_n, SYNC_STAGES));
endmodule

bind freq_word_bank fwb_check #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .core_clk    (core_clk),
  .rst_act     (rst_act),
  .rst_q       (rst_q),
  .upd_n       (upd_n),
  .upd_live    (upd_live),
  .mst_fb      (mst_fb),
  .mst_of      (mst_of),
  .center_term (center_term),
  .offset_word (offset_word),
  .accum_fb_en (accum_fb_en)
);

// File: tb/tb_freq_word_bank.sv
`timescale 1ns/1ps
module tb_freq_word_bank;
  logic        core_clk = 1'b0;
  logic        rst_n    = 1'b0;
  logic        upd_n    = 1'b0;
  logic        wr_clk   = 1'b0;
  logic        wr_en_n  = 1'b1;
  logic [3:0]  wr_addr  = '0;
  logic [7:0]  wr_data  = '0;
  logic [47:0] center_term, offset_word;
  logic        accum_fb_en;

  int    errors = 0, checks = 0;
  int    wr_ratio = 1;
  bit    cmp_on = 0, done = 0;
  string cur_req = "R3";

  // Behavioural model
  logic [7:0] mm [12];
  logic [7:0] sm [12];
  logic mce, mfb, sce, sfb;
  bit   mrst_q = 0;
  bit   hist[$];

  freq_word_bank dut (
    .core_clk(core_clk), .rst_n(rst_n), .upd_n(upd_n), .wr_clk(wr_clk),
    .wr_en_n(wr_en_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .center_term(center_term), .offset_word(offset_word), .accum_fb_en(accum_fb_en));

  always #5 core_clk = ~core_clk;

  function automatic void model_defaults();
    for (int i = 0; i < 12; i++) mm[i] = (i == 5) ? 8'h40 : 8'h00;
    mce = 1'b1; mfb = 1'b1;
  endfunction

  function automatic logic [47:0] word_of(input int base);
    logic [47:0] v = '0;
    for (int i = 0; i < 6; i++) v = v | (48'(sm[base+i]) << (8*i));
    return v;
  endfunction

  function automatic logic [47:0] exp_cf();
    return sce ? word_of(0) : 48'h0;
  endfunction

  function automatic void model_write(input int a, input logic [7:0] d, input logic en_n);
    if (mrst_q || en_n) return;
    if (a < 12)       mm[a] = d;
    else if (a == 12) mce = d[0];
    else if (a == 13) mfb = d[5];
  endfunction

  // Model step on every core edge
  always @(posedge core_clk) begin
    bit ract, cp;
    ract = !rst_n && !upd_n;
    if (ract) begin
      model_defaults();
      for (int i = 0; i < 12; i++) sm[i] = mm[i];
      sce = 1'b1; sfb = 1'b1;
      hist = '{1'b1, 1'b1};
    end else begin
      cp = hist[0];
      void'(hist.pop_front());
      hist.push_back(!upd_n);
      if (cp) begin
        for (int i = 0; i < 12; i++) sm[i] = mm[i];
        sce = mce; sfb = mfb;
      end
    end
    mrst_q = ract;
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison
  always @(negedge core_clk) if (cmp_on) begin
    chk({cur_req, " center_term"}, center_term, exp_cf());
    chk({cur_req, " offset_word"}, offset_word, word_of(6));
    chk({cur_req, " accum_fb_en"}, 48'(accum_fb_en), 48'(sfb));
  end

  task automatic wr(input int a, input logic [7:0] d, input logic en_n = 1'b0);
    @(negedge core_clk);
    wr_addr = 4'(a); wr_data = d; wr_en_n = en_n;
    #2 wr_clk = 1'b1;
    model_write(a, d, en_n);
    repeat (wr_ratio) @(negedge core_clk);
    #2 wr_clk = 1'b0;
    wr_en_n = 1'b1;
    repeat (wr_ratio - 1) @(negedge core_clk);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge core_clk);
  endtask

  task automatic write_word(input int base, input logic [47:0] w);
    for (int i = 0; i < 6; i++) wr(base + i, w[8*i +: 8]);
  endtask

  localparam logic [47:0] CF_DEF = 48'h4000_0000_0000;
  localparam logic [47:0] CF_A   = 48'h1122_3344_5566;
  localparam logic [47:0] OF_A   = 48'h0A0B_0C0D_0E0F;

  initial begin
    model_defaults();
    for (int i = 0; i < 12; i++) sm[i] = mm[i];
    sce = 1'b1; sfb = 1'b1;
    hist = '{1'b1, 1'b1};
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    cmp_on = 1;

    // R3 reset values
    cur_req = "R3";
    chk("R3 center default", center_term, CF_DEF);
    chk("R3 offset default", offset_word, 48'h0);
    chk("R3 feedback default", 48'(accum_fb_en), 48'h1);

    // R8 writes with update inactive do not show; then a single pulse
    cur_req = "R8";
    upd_n = 1'b1; cycles(3);
    write_word(0, CF_A);
    write_word(6, OF_A);
    cycles(2);
    chk("R8 held before pulse", center_term, CF_DEF);
    @(negedge core_clk) upd_n = 1'b0;
    cur_req = "R9";
    for (int i = 0; i < 5; i++) begin
      @(negedge core_clk);
      if (i < 2) chk("R9 not yet copied", center_term, CF_DEF);
      else       chk("R9 copied on third edge", center_term, CF_A);
      checks++;
      if (center_term !== CF_DEF && center_term !== CF_A) begin
        errors++;
        $display("FAIL R8 mixed word actual=%h expected=%h or %h", center_term, CF_DEF, CF_A);
      end
    end
    upd_n = 1'b1;
    cur_req = "R2";
    chk("R2 center byte order", center_term, CF_A);
    chk("R2 offset byte order", offset_word, OF_A);
    cycles(3);

    // R1 disabled strobe
    cur_req = "R1";
    wr(0, 8'hFF, 1'b1);
    @(negedge core_clk) upd_n = 1'b0;
    cycles(4);
    chk("R1 write enable high ignored", center_term, CF_A);

    // R7 continuous transfer, slower strobe
    cur_req = "R7";
    wr_ratio = 3;
    wr(0, 8'h77);
    cycles(3);
    chk("R7 partial byte visible", center_term, 48'h1122_3344_5577);
    wr(7, 8'hC3);
    cycles(3);
    chk("R7 offset byte visible", offset_word, 48'h0A0B_0C0D_C30F);

    // R4 center enable
    cur_req = "R4";
    wr_ratio = 2;
    wr(12, 8'hFE);
    cycles(3);
    chk("R4 center disabled", center_term, 48'h0);
    wr(12, 8'h01);
    cycles(3);
    chk("R4 center contents kept", center_term, 48'h1122_3344_5577);

    // R5 feedback enable, R6 ignored bits and addresses
    cur_req = "R5";
    wr(13, 8'hDF);
    cycles(3);
    chk("R5 feedback cleared", 48'(accum_fb_en), 48'h0);
    wr(13, 8'h20);
    cycles(3);
    chk("R5 feedback set", 48'(accum_fb_en), 48'h1);
    cur_req = "R6";
    wr(12, 8'hFF);
    wr(14, 8'hFF);
    wr(15, 8'h00);
    cycles(3);
    chk("R6 center unchanged", center_term, 48'h1122_3344_5577);
    chk("R6 offset unchanged", offset_word, 48'h0A0B_0C0D_C30F);

    // R10 reset without update low is ignored
    cur_req = "R10";
    wr_ratio = 1;
    @(negedge core_clk) upd_n = 1'b1;
    cycles(3);
    rst_n = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    cycles(2);
    chk("R10 no reset with update high", center_term, 48'h1122_3344_5577);
    @(negedge core_clk) upd_n = 1'b0;
    cycles(4);
    chk("R10 shadow kept", offset_word, 48'h0A0B_0C0D_C30F);

    // R11 write during the release window is dropped
    cur_req = "R11";
    rst_n = 1'b0;
    cycles(3);
    @(negedge core_clk);
    rst_n = 1'b1;
    wr_addr = 4'd6; wr_data = 8'h55; wr_en_n = 1'b0;
    #2 wr_clk = 1'b1;
    model_write(6, 8'h55, 1'b0);
    @(negedge core_clk);
    #2 wr_clk = 1'b0;
    wr_en_n = 1'b1;
    cycles(4);
    chk("R11 early write dropped", offset_word, 48'h0);
    chk("R3 center after reset", center_term, CF_DEF);
    wr(6, 8'h55);
    cycles(4);
    chk("R11 later write taken", offset_word, 48'h55);

    cmp_on = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule